// File: doc/BRIEF.md
# Tagged Register File with Trap Controller

This block is a 256-entry register file in which every 32-bit data word travels with a 4-bit type tag and a 4-bit provenance field. A write stores all three together. Two read ports return data, tag and provenance for any register combinationally. Each read port can be asked to check its operand against an expected type tag. A failed check raises a hardware trap, which the built-in trap controller settles in the cycle that follows.

The trap controller looks up a 16-entry handler table, indexed by the offending operand's stored tag. Each entry holds a valid bit and a handler vector. A trap is taken only when its entry is valid and fewer than eight traps are already nested. A nesting counter records how deep the current trap chain is, and a return-from-trap input lowers it. Any other trap counts as unhandled. In host mode an unhandled trap is passed to software on a one-cycle trap-to-host pulse. In reflex mode it latches an emergency stop that only reset clears.

Instruction decode and arithmetic sit outside the block. They drive the addresses, the check enables and the expected tags, and they act on the trap outputs.

Top module: `tagrf_trap_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads tag 0 (Uninitialized) and provenance 0. Every handler entry is invalid with vector 0. The nesting depth is 0. `trap_taken`, `trap_to_host`, `estop`, `trap_index` and `trap_vector` are all 0.
- R2: A write stores data, tag and provenance in one clock edge. The read ports show the new contents right after that edge. A check made in the same cycle as the write sees the old contents.
- R3: Tag codes are 0 Uninitialized, 1 Bool, 2 Unsigned and 3 Signed; codes 4 to 15 are further types. A port whose check enable is high traps when its stored tag differs from its expected tag. A port whose check enable is low never traps.
- R4: A checked read of a register whose tag is 0 always traps, including when the expected tag is also 0.
- R5: The trap cause is the stored tag of the offending operand. When both ports fail, port A sets the cause. `trap_index` and `trap_vector` (the handler entry selected by the cause) update on the clock edge that samples the trap, and hold their values otherwise.
- R6: A handler-table write sets the valid bit and the vector of one entry. A trap in the same cycle uses the entry's old contents.
- R7: A trap whose entry is valid, arriving while the depth is below 8, pulses `trap_taken` for one cycle and raises the depth by one.
- R8: An unhandled trap (invalid entry, or depth already 8) leaves the depth unchanged. In host mode (`host_mode`=1) it pulses `trap_to_host` for one cycle. `trap_taken` and `trap_to_host` are never high together.
- R9: An unhandled trap in reflex mode (`host_mode`=0) sets `estop`, which stays high until reset.
- R10: `trap_ret` lowers the depth by one, and the depth never goes below 0. When a trap and a return arrive in the same cycle, the trap is judged on the depth before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Data word to store |
| wr_tag | input | 4 | Type tag to store |
| wr_prov | input | 4 | Provenance to store |
| rd_addr_a | input | 8 | Read port A address |
| chk_en_a | input | 1 | Check port A operand |
| exp_tag_a | input | 4 | Expected tag for port A |
| rd_addr_b | input | 8 | Read port B address |
| chk_en_b | input | 1 | Check port B operand |
| exp_tag_b | input | 4 | Expected tag for port B |
| tbl_we | input | 1 | Handler-table write strobe |
| tbl_idx | input | 4 | Handler entry to write |
| tbl_valid | input | 1 | Valid bit for the entry |
| tbl_vector | input | 16 | Handler vector for the entry |
| host_mode | input | 1 | 1 = host mode, 0 = reflex mode |
| trap_ret | input | 1 | Return from the current trap |
| rd_data_a | output | 32 | Port A data |
| rd_tag_a | output | 4 | Port A type tag |
| rd_prov_a | output | 4 | Port A provenance |
| rd_data_b | output | 32 | Port B data |
| rd_tag_b | output | 4 | Port B type tag |
| rd_prov_b | output | 4 | Port B provenance |
| trap_taken | output | 1 | One-cycle pulse: handled trap |
| trap_index | output | 4 | Cause of the latest trap |
| trap_vector | output | 16 | Handler vector for the latest trap |
| trap_to_host | output | 1 | One-cycle pulse: unhandled trap in host mode |
| estop | output | 1 | Sticky emergency stop |

## Verification
On every cycle the assertions check these properties:
- A checked read of an Uninitialized register raises a trap.
- Table and register writes land in the addressed entry.
- The nesting depth never exceeds eight.
- A trap at full depth in host mode goes to the host.
- An invalid entry in reflex mode stops the block.
- Emergency stop never falls.
- A taken trap and a host trap never coincide.
- A return at depth zero leaves the depth at zero.

Some behaviour only the bench's scenarios can show:
- That the depth limit counts exactly eight nested traps, and that returns give room back one at a time.
- That port A wins when both ports fail.
- That a check made in the same cycle as a write, a table update or a return sees the old state.
- That reset clears the tags of registers that were written before it.

// File: rtl/tagrf_pkg.sv
// Package: shared widths and type-tag codes for the tagged register file.
// Assumes tag code 0 means "never written"; the trap controller relies on it.
package tagrf_pkg;
    localparam int TAG_W     = 4;
    localparam int PROV_W    = 4;
    localparam int NUM_PORTS = 2;

    localparam logic [TAG_W-1:0] TAG_UNINIT   = 4'd0;
    localparam logic [TAG_W-1:0] TAG_BOOL     = 4'd1;
    localparam logic [TAG_W-1:0] TAG_UNSIGNED = 4'd2;
    localparam logic [TAG_W-1:0] TAG_SIGNED   = 4'd3;
endpackage

// File: rtl/tagrf_storage.sv
// Module: tagrf_storage
// Holds NUM_REGS data words, each with a type tag and a provenance field.
// One write port updates all three at once; NUM_PORTS read ports are
// combinational. Assumes addresses are in range. Reset clears only the
// tags and provenance; data words keep whatever they held.
module tagrf_storage
    import tagrf_pkg::*;
#(
    parameter  int NUM_REGS = 256,
    parameter  int DATA_W   = 32,
    localparam int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic [TAG_W-1:0]                     wr_tag,
    input  logic [PROV_W-1:0]                    wr_prov,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     rd_addr,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]     rd_data,
    output logic [NUM_PORTS-1:0][TAG_W-1:0]      rd_tag,
    output logic [NUM_PORTS-1:0][PROV_W-1:0]     rd_prov
);
    logic [DATA_W-1:0] data_q [NUM_REGS];
    logic [TAG_W-1:0]  tag_q  [NUM_REGS];
    logic [PROV_W-1:0] prov_q [NUM_REGS];

    // Purpose: store data words (no reset, data is meaningless until written).
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_addr] <= wr_data;
        end
    end

    // Purpose: store tags and provenance; reset marks every register Uninitialized.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                tag_q[i]  <= TAG_UNINIT;
                prov_q[i] <= '0;
            end
        end else if (wr_en) begin
            tag_q[wr_addr]  <= wr_tag;
            prov_q[wr_addr] <= wr_prov;
        end
    end

    // Purpose: one combinational read path per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        assign rd_data[p] = data_q[rd_addr[p]];
        assign rd_tag[p]  = tag_q[rd_addr[p]];
        assign rd_prov[p] = prov_q[rd_addr[p]];
    end

    // R2: a write lands its tag, provenance and data in the addressed entry.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tag_q[$past(wr_addr)]  == $past(wr_tag)  &&
                   prov_q[$past(wr_addr)] == $past(wr_prov) &&
                   data_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/tagrf_tagcheck.sv
// Module: tagrf_tagcheck
// Compares each port's stored tag with its expected tag when that port's
// check is enabled. An Uninitialized tag always fails. The cause is the
// stored tag of the lowest-numbered failing port. Purely combinational;
// the clock and reset feed only the assertions.
module tagrf_tagcheck
    import tagrf_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             chk_en,
    input  logic [NUM_PORTS-1:0][TAG_W-1:0]  exp_tag,
    input  logic [NUM_PORTS-1:0][TAG_W-1:0]  rd_tag,
    output logic                             trap_req,
    output logic [TAG_W-1:0]                 cause
);
    logic [NUM_PORTS-1:0] mism;

    // Purpose: flag a failing check on each port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        assign mism[p] = chk_en[p] &&
                         ((rd_tag[p] == TAG_UNINIT) || (rd_tag[p] != exp_tag[p]));

        // R4: a checked Uninitialized operand always raises a trap.
        p_uninit_traps_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (chk_en[p] && rd_tag[p] == TAG_UNINIT) |-> trap_req);
    end

    assign trap_req = |mism;

    // Purpose: pick the cause from the lowest-numbered failing port.
    always_comb begin
        cause = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (mism[p]) begin
                cause = rd_tag[p];
            end
        end
    end

    // R3: with every check disabled there is no trap.
    p_unchecked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en == '0) |-> !trap_req);
endmodule

// File: rtl/tagrf_handler_tbl.sv
// Module: tagrf_handler_tbl
// A table of handler entries, one per trap cause, each a valid bit plus a
// vector. It has one write port and one combinational lookup. A lookup in
// the same cycle as a write to the same entry returns the old contents.
module tagrf_handler_tbl #(
    parameter  int NUM_ENTRIES = 16,
    parameter  int VEC_W       = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tw_en,
    input  logic [IDX_W-1:0] tw_idx,
    input  logic             tw_valid,
    input  logic [VEC_W-1:0] tw_vector,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_valid,
    output logic [VEC_W-1:0] lk_vector
);
    logic [NUM_ENTRIES-1:0] valid_q;
    logic [VEC_W-1:0]       vec_q [NUM_ENTRIES];

    // Purpose: hold the entries; reset invalidates them and zeroes the vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                vec_q[i] <= '0;
            end
        end else if (tw_en) begin
            valid_q[tw_idx] <= tw_valid;
            vec_q[tw_idx]   <= tw_vector;
        end
    end

    assign lk_valid  = valid_q[lk_idx];
    assign lk_vector = vec_q[lk_idx];

    // R6: a table write lands in the addressed entry.
    p_tbl_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tw_en |=> (valid_q[$past(tw_idx)] == $past(tw_valid) &&
                   vec_q[$past(tw_idx)]   == $past(tw_vector)));
endmodule

// File: rtl/tagrf_trap_ctrl.sv
// Module: tagrf_trap_ctrl
// Settles each trap request as handled or unhandled and keeps the nesting
// depth. A trap is handled when its entry is valid and depth < MAX_DEPTH.
// Outputs are registered: they show one cycle after the request.
// Assumes the lookup inputs already reflect the current cause.
module tagrf_trap_ctrl #(
    parameter  int MAX_DEPTH = 8,
    parameter  int VEC_W     = 16,
    parameter  int IDX_W     = 4,
    localparam int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic [IDX_W-1:0] cause,
    input  logic             entry_valid,
    input  logic [VEC_W-1:0] entry_vector,
    input  logic             host_mode,
    input  logic             trap_ret,
    output logic             trap_taken,
    output logic [IDX_W-1:0] trap_index,
    output logic [VEC_W-1:0] trap_vector,
    output logic             trap_to_host,
    output logic             estop
);
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(MAX_DEPTH);

    logic [DEPTH_W-1:0] depth_q;
    logic               accept;
    logic               unhandled;
    logic               dec;

    assign accept    = trap_req && entry_valid && (depth_q < DEPTH_MAX);
    assign unhandled = trap_req && !accept;
    assign dec       = trap_ret && (depth_q != '0);

    // Purpose: track nesting depth; a trap is judged on the depth before this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else begin
            unique case ({accept, dec})
                2'b10:   depth_q <= depth_q + 1'b1;
                2'b01:   depth_q <= depth_q - 1'b1;
                default: depth_q <= depth_q;
            endcase
        end
    end

    // Purpose: register the outcome pulses and the sticky emergency stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_taken   <= 1'b0;
            trap_to_host <= 1'b0;
            estop        <= 1'b0;
        end else begin
            trap_taken   <= accept;
            trap_to_host <= unhandled && host_mode;
            estop        <= estop || (unhandled && !host_mode);
        end
    end

    // Purpose: hold the cause and vector of the most recent trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_index  <= '0;
            trap_vector <= '0;
        end else if (trap_req) begin
            trap_index  <= cause;
            trap_vector <= entry_vector;
        end
    end

    // R7: depth never exceeds the nesting limit.
    p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DEPTH_MAX);

    // R8: a trap at full depth in host mode goes to the host.
    p_full_to_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && depth_q == DEPTH_MAX && host_mode) |=> (trap_to_host && !trap_taken));

    // R8: the two outcome pulses are exclusive.
    p_outcome_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_taken && trap_to_host));

    // R9: an invalid entry in reflex mode stops the block.
    p_reflex_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !entry_valid && !host_mode) |=> estop);

    // R9: emergency stop is sticky.
    p_estop_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        estop |=> estop);

    // R10: a return at depth zero keeps the depth at zero.
    p_ret_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_q == '0 && trap_ret && !trap_req) |=> depth_q == '0);
endmodule

// File: rtl/tagrf_trap_top.sv
// Module: tagrf_trap_top
// Tagged register file with operand tag checking and a bounded-depth trap
// controller. Wires storage, tag check, handler table and trap control.
// Assumes the handler table has one entry per tag code.
module tagrf_trap_top
    import tagrf_pkg::*;
#(
    parameter  int NUM_REGS  = 256,
    parameter  int DATA_W    = 32,
    parameter  int MAX_DEPTH = 8,
    parameter  int VEC_W     = 16,
    localparam int ADDR_W    = $clog2(NUM_REGS),
    localparam int NUM_HND   = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [PROV_W-1:0] wr_prov,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic              chk_en_a,
    input  logic [TAG_W-1:0]  exp_tag_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    input  logic              chk_en_b,
    input  logic [TAG_W-1:0]  exp_tag_b,
    input  logic              tbl_we,
    input  logic [TAG_W-1:0]  tbl_idx,
    input  logic              tbl_valid,
    input  logic [VEC_W-1:0]  tbl_vector,
    input  logic              host_mode,
    input  logic              trap_ret,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [TAG_W-1:0]  rd_tag_a,
    output logic [PROV_W-1:0] rd_prov_a,
    output logic [DATA_W-1:0] rd_data_b,
    output logic [TAG_W-1:0]  rd_tag_b,
    output logic [PROV_W-1:0] rd_prov_b,
    output logic              trap_taken,
    output logic [TAG_W-1:0]  trap_index,
    output logic [VEC_W-1:0]  trap_vector,
    output logic              trap_to_host,
    output logic              estop
);
    logic [NUM_PORTS-1:0][ADDR_W-1:0] rd_addr;
    logic [NUM_PORTS-1:0][DATA_W-1:0] rd_data;
    logic [NUM_PORTS-1:0][TAG_W-1:0]  rd_tag;
    logic [NUM_PORTS-1:0][PROV_W-1:0] rd_prov;
    logic [NUM_PORTS-1:0]             chk_en;
    logic [NUM_PORTS-1:0][TAG_W-1:0]  exp_tag;
    logic                             trap_req;
    logic [TAG_W-1:0]                 cause;
    logic                             hnd_valid;
    logic [VEC_W-1:0]                 hnd_vector;

    // Port A is index 0, so it has priority in the cause selection.
    assign rd_addr = {rd_addr_b, rd_addr_a};
    assign chk_en  = {chk_en_b, chk_en_a};
    assign exp_tag = {exp_tag_b, exp_tag_a};

    assign rd_data_a = rd_data[0];
    assign rd_tag_a  = rd_tag[0];
    assign rd_prov_a = rd_prov[0];
    assign rd_data_b = rd_data[1];
    assign rd_tag_b  = rd_tag[1];
    assign rd_prov_b = rd_prov[1];

    tagrf_storage #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_tag  (wr_tag),
        .wr_prov (wr_prov),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rd_tag  (rd_tag),
        .rd_prov (rd_prov)
    );

    tagrf_tagcheck u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_en   (chk_en),
        .exp_tag  (exp_tag),
        .rd_tag   (rd_tag),
        .trap_req (trap_req),
        .cause    (cause)
    );

    tagrf_handler_tbl #(
        .NUM_ENTRIES (NUM_HND),
        .VEC_W       (VEC_W)
    ) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tw_en     (tbl_we),
        .tw_idx    (tbl_idx),
        .tw_valid  (tbl_valid),
        .tw_vector (tbl_vector),
        .lk_idx    (cause),
        .lk_valid  (hnd_valid),
        .lk_vector (hnd_vector)
    );

    tagrf_trap_ctrl #(
        .MAX_DEPTH (MAX_DEPTH),
        .VEC_W     (VEC_W),
        .IDX_W     (TAG_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .trap_req     (trap_req),
        .cause        (cause),
        .entry_valid  (hnd_valid),
        .entry_vector (hnd_vector),
        .host_mode    (host_mode),
        .trap_ret     (trap_ret),
        .trap_taken   (trap_taken),
        .trap_index   (trap_index),
        .trap_vector  (trap_vector),
        .trap_to_host (trap_to_host),
        .estop        (estop)
    );
endmodule

// File: tb/tagrf_trap_top_test.sv
`timescale 1ns/100ps
module tagrf_trap_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_tag, wr_prov;
    logic [7:0]  rd_addr_a, rd_addr_b;
    logic        chk_en_a, chk_en_b;
    logic [3:0]  exp_tag_a, exp_tag_b;
    logic        tbl_we, tbl_valid;
    logic [3:0]  tbl_idx;
    logic [15:0] tbl_vector;
    logic        host_mode, trap_ret;
    logic [31:0] rd_data_a, rd_data_b;
    logic [3:0]  rd_tag_a, rd_prov_a, rd_tag_b, rd_prov_b;
    logic        trap_taken, trap_to_host, estop;
    logic [3:0]  trap_index;
    logic [15:0] trap_vector;

    always #2.5 clk = ~clk;

    tagrf_trap_top uut (.*);

    int nchk = 0;
    int nfail = 0;

    // Reference model state
    logic [31:0] mdata [256];
    logic [3:0]  mtag  [256];
    logic [3:0]  mprov [256];
    bit          mwr   [256];
    bit          mval  [16];
    logic [15:0] mvec  [16];
    int          mdepth;
    bit          mtk, mth, mest;
    logic [3:0]  midx;
    logic [15:0] mvq;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            mtag[i] = 4'd0; mprov[i] = 4'd0; mwr[i] = 1'b0;
        end
        for (int i = 0; i < 16; i++) begin
            mval[i] = 1'b0; mvec[i] = 16'd0;
        end
        mdepth = 0; mtk = 0; mth = 0; mest = 0; midx = 0; mvq = 0;
    endtask

    task automatic clear_in();
        wr_en = 0; wr_addr = 0; wr_data = 0; wr_tag = 0; wr_prov = 0;
        chk_en_a = 0; chk_en_b = 0; exp_tag_a = 0; exp_tag_b = 0;
        tbl_we = 0; tbl_idx = 0; tbl_valid = 0; tbl_vector = 0; trap_ret = 0;
    endtask

    task automatic do_reset();
        clear_in();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        model_reset();
    endtask

    // Compare read ports against the model (R2)
    task automatic check_reads();
        check("R2", "tag_a",  rd_tag_a,  mtag[rd_addr_a]);
        check("R2", "prov_a", rd_prov_a, mprov[rd_addr_a]);
        check("R2", "tag_b",  rd_tag_b,  mtag[rd_addr_b]);
        check("R2", "prov_b", rd_prov_b, mprov[rd_addr_b]);
        if (mwr[rd_addr_a]) check("R2", "data_a", rd_data_a, mdata[rd_addr_a]);
        if (mwr[rd_addr_b]) check("R2", "data_b", rd_data_b, mdata[rd_addr_b]);
    endtask

    // One clock with the current inputs; predicts and checks all outputs.
    task automatic step();
        logic [3:0] ta, tb, cause;
        bit ma, mb, trap, acc, dec;
        ta = mtag[rd_addr_a];
        tb = mtag[rd_addr_b];
        ma = chk_en_a && (ta == 4'd0 || ta != exp_tag_a);
        mb = chk_en_b && (tb == 4'd0 || tb != exp_tag_b);
        trap  = ma || mb;
        cause = ma ? ta : tb;
        acc   = trap && mval[cause] && (mdepth < 8);
        dec   = trap_ret && (mdepth > 0);
        mtk = acc;
        mth = trap && !acc && host_mode;
        if (trap && !acc && !host_mode) mest = 1'b1;
        if (trap) begin
            midx = cause;
            mvq  = mvec[cause];
        end
        mdepth = mdepth + (acc ? 1 : 0) - (dec ? 1 : 0);
        if (wr_en) begin
            mdata[wr_addr] = wr_data; mtag[wr_addr] = wr_tag;
            mprov[wr_addr] = wr_prov; mwr[wr_addr] = 1'b1;
        end
        if (tbl_we) begin
            mval[tbl_idx] = tbl_valid; mvec[tbl_idx] = tbl_vector;
        end
        @(posedge clk);
        #1;
        check("R7", "trap_taken",   trap_taken,   mtk);
        check("R8", "trap_to_host", trap_to_host, mth);
        check("R9", "estop",        estop,        mest);
        check("R5", "trap_index",   trap_index,   midx);
        check("R6", "trap_vector",  trap_vector,  mvq);
        check_reads();
    endtask

    task automatic wr_reg(logic [7:0] a, logic [31:0] d, logic [3:0] t, logic [3:0] p);
        clear_in();
        wr_en = 1; wr_addr = a; wr_data = d; wr_tag = t; wr_prov = p;
        step();
    endtask

    task automatic wr_tbl(logic [3:0] i, bit v, logic [15:0] vec);
        clear_in();
        tbl_we = 1; tbl_idx = i; tbl_valid = v; tbl_vector = vec;
        step();
    endtask

    task automatic chk_a(logic [7:0] a, logic [3:0] e);
        clear_in();
        chk_en_a = 1; rd_addr_a = a; exp_tag_a = e;
        step();
    endtask

    task automatic ret_once();
        clear_in();
        trap_ret = 1;
        step();
    endtask

    initial begin
        #1000000;
        nchk++; nfail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int ntaken;
        void'($urandom(32'd24681));
        host_mode = 1;
        rd_addr_a = 0; rd_addr_b = 0;
        do_reset();

        // R1: reset state
        rd_addr_a = 8'd0; rd_addr_b = 8'd255;
        #1;
        check("R1", "tag after reset a", rd_tag_a, 4'd0);
        check("R1", "tag after reset b", rd_tag_b, 4'd0);
        check("R1", "prov after reset", rd_prov_b, 4'd0);
        check("R1", "trap_taken", trap_taken, 1'b0);
        check("R1", "trap_to_host", trap_to_host, 1'b0);
        check("R1", "estop", estop, 1'b0);
        check("R1", "trap_index", trap_index, 4'd0);

        // R4: Uninitialized always traps, even against expected 0; entry invalid -> host
        chk_a(8'd5, 4'd0);
        check("R4", "uninit trap to host", trap_to_host, 1'b1);
        check("R4", "uninit not taken", trap_taken, 1'b0);

        // R2: writes of each tag kind
        wr_reg(8'd1, 32'hDEAD_0001, 4'd1, 4'd9);
        wr_reg(8'd2, 32'h0000_1234, 4'd2, 4'd3);
        wr_reg(8'd3, 32'hFFFF_FFFE, 4'd3, 4'd5);
        wr_reg(8'd4, 32'h00C0_FFEE, 4'd7, 4'd15);
        clear_in(); rd_addr_a = 8'd4; rd_addr_b = 8'd3; #1;
        check("R2", "written tag 7", rd_tag_a, 4'd7);
        check("R2", "written prov 15", rd_prov_a, 4'd15);
        check("R2", "written data", rd_data_b, 32'hFFFF_FFFE);

        // R6: handler entries
        wr_tbl(4'd1, 1, 16'h1100);
        wr_tbl(4'd2, 1, 16'h2200);
        wr_tbl(4'd3, 1, 16'h3300);
        wr_tbl(4'd7, 1, 16'h7700);

        // R3: matching tag and disabled check do not trap
        chk_a(8'd2, 4'd2);
        check("R3", "match no trap", trap_taken | trap_to_host, 1'b0);
        clear_in(); rd_addr_a = 8'd9; exp_tag_a = 4'd3; step();
        check("R3", "unchecked no trap", trap_taken | trap_to_host, 1'b0);

        // R7: mismatch with valid handler
        chk_a(8'd1, 4'd2);
        check("R7", "handled taken", trap_taken, 1'b1);
        check("R6", "vector of entry 1", trap_vector, 16'h1100);

        // R5: both ports fail, port A (tag 3) wins over port B (tag 7)
        clear_in();
        chk_en_a = 1; rd_addr_a = 8'd3; exp_tag_a = 4'd1;
        chk_en_b = 1; rd_addr_b = 8'd4; exp_tag_b = 4'd1;
        step();
        check("R5", "port A priority", trap_index, 4'd3);
        // R5: only port B fails
        clear_in();
        chk_en_a = 1; rd_addr_a = 8'd2; exp_tag_a = 4'd2;
        chk_en_b = 1; rd_addr_b = 8'd4; exp_tag_b = 4'd1;
        step();
        check("R5", "port B cause", trap_index, 4'd7);
        check("R5", "port B vector", trap_vector, 16'h7700);

        // R7/R8: depth is now 3; five more fill it to 8, the next overflows
        for (int i = 0; i < 5; i++) chk_a(8'd1, 4'd3);
        check("R7", "eighth nested taken", trap_taken, 1'b1);
        chk_a(8'd1, 4'd3);
        check("R8", "ninth nested to host", trap_to_host, 1'b1);
        check("R8", "ninth nested not taken", trap_taken, 1'b0);

        // R10: one return frees one level
        ret_once();
        chk_a(8'd1, 4'd3);
        check("R10", "after return taken", trap_taken, 1'b1);
        // R10: trap and return together at depth 8 -> judged on old depth
        clear_in(); chk_en_a = 1; rd_addr_a = 8'd1; exp_tag_a = 4'd0; trap_ret = 1; step();
        check("R10", "trap with return at full depth", trap_to_host, 1'b1);
        // R10: floor at zero: 20 returns, then exactly 8 traps fit
        for (int i = 0; i < 20; i++) ret_once();
        ntaken = 0;
        for (int i = 0; i < 9; i++) begin
            chk_a(8'd2, 4'd1);
            if (trap_taken) ntaken++;
        end
        check("R10", "traps accepted after floor", ntaken, 8);
        for (int i = 0; i < 8; i++) ret_once();

        // R2: same-cycle write and check sees old tag (1), so it traps
        clear_in();
        wr_en = 1; wr_addr = 8'd1; wr_data = 32'h5; wr_tag = 4'd2; wr_prov = 4'd1;
        chk_en_a = 1; rd_addr_a = 8'd1; exp_tag_a = 4'd2;
        step();
        check("R2", "same-cycle check sees old tag", trap_taken, 1'b1);
        chk_a(8'd1, 4'd2);
        check("R2", "next-cycle check sees new tag", trap_taken, 1'b0);
        ret_once();

        // R6: table write and trap in the same cycle use the old (invalid) entry
        clear_in();
        tbl_we = 1; tbl_idx = 4'd0; tbl_valid = 1; tbl_vector = 16'h0A0A;
        chk_en_a = 1; rd_addr_a = 8'd200; exp_tag_a = 4'd0;
        step();
        check("R6", "old entry used", trap_to_host, 1'b1);
        chk_a(8'd200, 4'd0);
        check("R6", "new entry used", trap_taken, 1'b1);
        check("R6", "new entry vector", trap_vector, 16'h0A0A);
        ret_once();

        // Random mix in host mode
        for (int n = 0; n < 3000; n++) begin
            clear_in();
            if ($urandom_range(0, 2) == 0) begin
                wr_en = 1; wr_addr = 8'($urandom_range(0, 15));
                wr_data = $urandom; wr_tag = 4'($urandom_range(0, 5));
                wr_prov = 4'($urandom);
            end
            if ($urandom_range(0, 9) == 0) begin
                tbl_we = 1; tbl_idx = 4'($urandom_range(0, 5));
                tbl_valid = 1'($urandom); tbl_vector = 16'($urandom);
            end
            rd_addr_a = 8'($urandom_range(0, 15));
            rd_addr_b = 8'($urandom_range(0, 15));
            chk_en_a = 1'($urandom); chk_en_b = 1'($urandom);
            exp_tag_a = 4'($urandom_range(0, 5));
            exp_tag_b = 4'($urandom_range(0, 5));
            trap_ret = ($urandom_range(0, 2) == 0);
            step();
        end

        // R9: unhandled trap in reflex mode latches emergency stop
        for (int i = 0; i < 10; i++) ret_once();
        wr_tbl(4'd0, 0, 16'd0);
        host_mode = 0;
        chk_a(8'd250, 4'd1);
        check("R9", "reflex estop set", estop, 1'b1);
        check("R9", "reflex no host pulse", trap_to_host, 1'b0);
        for (int i = 0; i < 4; i++) chk_a(8'd2, 4'd2);
        check("R9", "estop sticky", estop, 1'b1);

        // R1: reset clears estop and previously written tags
        do_reset();
        host_mode = 1;
        rd_addr_a = 8'd2; rd_addr_b = 8'd4; #1;
        check("R1", "estop after reset", estop, 1'b0);
        check("R1", "written reg tag cleared", rd_tag_a, 4'd0);
        check("R1", "written reg prov cleared", rd_prov_b, 4'd0);
        chk_a(8'd3, 4'd3);
        check("R1", "entries invalid after reset", trap_to_host, 1'b1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule